// File: doc/BRIEF.md
# Asynchronous Transmit Retry Scheduler

This block decides which asynchronous packet goes onto the serial link next and what happens after the link answers. Three producers compete for the transmitter: a request queue, a response queue and a physical-response source. Each offers one packet descriptor, reduced here to a tag, through a valid/ready handshake. After a packet is launched, the scheduler waits for its acknowledge code. The code either completes the packet or, when it signals busy, schedules the same packet to be sent again.

Two retry policies are available, chosen by a mode input. In count mode, a busy packet is resent a programmed number of times. In time mode, resending continues until a programmed number of 8 kHz cycle ticks has passed since the packet was first granted. Physical responses take the transmitter at packet boundaries only. A bus-reset event discards everything in flight or waiting, tells the queues to flush, and parks the scheduler until software pulses a resume input.

Top module: `at_retry_sched`

## Requirements
- R1: Only one packet is in flight at a time. From the handshake that grants a packet until its acknowledge is accepted (or a bus reset occurs), every ready output stays low.
- R2: A non-busy acknowledge completes the packet. One cycle after `ackValid`, `doneValid` pulses with the packet's source and tag, `doneCode` equal to the acknowledge code and `doneErr`=0. The retry count and elapsed time of the queue slot are cleared.
- R3: In count mode (`dualPhase`=0), a busy acknowledge causes a resend while fewer than `retryLimit` resends have been made. The busy acknowledge after resend number `retryLimit` completes the packet with `doneErr`=1 and the last code.
- R4: In time mode (`dualPhase`=1), a busy acknowledge causes a resend while fewer than `timeLimit` `cycleTick` pulses have been counted since the packet was granted. Otherwise it completes the packet with `doneErr`=1.
- R5: Acknowledge codes 4'h4, 4'h5 and 4'h6 are busy. Every other 4-bit code is non-busy.
- R6: The physical-response source is granted only while no packet is in flight. At a boundary it beats both queues and any pending resend. It is sent exactly once, and any acknowledge completes it with `doneErr`=0.
- R7: When both queues are valid, the scheduler picks the queue opposite to the last queue granted. After reset, the request queue is preferred.
- R8: One cycle after `busReset`, `flushQ` pulses and `halted` rises. Any in-flight or pending packet is dropped without a `doneValid`, and a late acknowledge is ignored.
- R9: While `halted` is 1, no ready output and no `txStart` is asserted. A `resume` pulse clears `halted` at the next edge.
- R10: The ready output is driven combinationally in the cycle the grant is taken. `txStart` pulses the following cycle with `txSrc` (0 request, 1 response, 2 physical) and `txTag` of the packet. A resend also pulses `txStart` with the held tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request queue offers a packet |
| reqReady | output | 1 | Request packet taken this cycle |
| reqTag | input | TAG_W | Request packet tag |
| rspValid | input | 1 | Response queue offers a packet |
| rspReady | output | 1 | Response packet taken this cycle |
| rspTag | input | TAG_W | Response packet tag |
| phyValid | input | 1 | Physical-response source offers a packet |
| phyReady | output | 1 | Physical packet taken this cycle |
| phyTag | input | TAG_W | Physical packet tag |
| dualPhase | input | 1 | 0 count-limited retry, 1 time-limited retry |
| retryLimit | input | CNT_W | Maximum resends in count mode |
| timeLimit | input | TIME_W | Tick budget in time mode |
| cycleTick | input | 1 | 8 kHz cycle strobe |
| ackValid | input | 1 | Acknowledge code present |
| ackCode | input | 4 | Acknowledge code |
| busReset | input | 1 | Bus reset event |
| resume | input | 1 | Software resume pulse |
| flushQ | output | 1 | Queues must discard their contents |
| halted | output | 1 | Transmission stopped after bus reset |
| txStart | output | 1 | Launch packet on the link |
| txSrc | output | 2 | Source of the launched packet |
| txTag | output | TAG_W | Tag of the launched packet |
| doneValid | output | 1 | Completion report valid |
| doneSrc | output | 2 | Source of the completed packet |
| doneTag | output | TAG_W | Tag of the completed packet |
| doneCode | output | 4 | Last acknowledge code |
| doneErr | output | 1 | Retry budget exhausted |

## Verification
The checker watches the ports every cycle for the properties that do not depend on history: no grant while a packet is in flight or while halted, at most one ready at a time, a launch one cycle after every grant, the flush and halt that follow a bus reset, error completions that carry only busy codes, and physical completions that never carry an error. The directed scenarios are the only evidence of behaviour that depends on history. These are the exact number of resends before an error in count mode, the tick budget in time mode, the retry counter being cleared after success, physical preemption ahead of a pending resend, round-robin alternation, and the dropping of a flushed packet so that only the new one is sent after resume.

// File: rtl/at_sched_pkg.sv
package at_sched_pkg;
  localparam int ACK_W = 4;

  typedef enum logic [1:0] {SRC_REQ = 2'd0, SRC_RSP = 2'd1, SRC_PHY = 2'd2} txSrc_e;

  typedef struct packed {
    logic grantQ;      // queue packet enters the slot
    logic grantRsp;    // qualifier: that packet is a response
    logic grantPhy;    // physical packet captured
    logic resend;      // slot packet relaunched
    logic bumpRetry;   // busy ack consumed a retry
    logic clearSlot;   // slot packet completed
    logic slotActive;  // slot holds a live packet
    logic report;      // latch completion record
    logic reportErr;   // completion is an exhaustion
    logic flushAll;    // bus reset
  } ctrlStrobe_t;

  function automatic logic isBusyAck(input logic [ACK_W-1:0] code);
    return (code == 4'h4) || (code == 4'h5) || (code == 4'h6);
  endfunction
endpackage

// File: rtl/at_sched_dpath.sv
module at_sched_dpath
  import at_sched_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 4,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic [TAG_W-1:0]  phyTag,
  input  logic              dualPhase,
  input  logic [CNT_W-1:0]  retryLimit,
  input  logic [TIME_W-1:0] timeLimit,
  input  logic              cycleTick,
  input  logic [ACK_W-1:0]  ackCode,
  output logic              exhausted,
  output logic              rrPreferRsp,
  output logic              sendingPhy,
  output logic [1:0]        txSrc,
  output logic [TAG_W-1:0]  txTag,
  output logic [1:0]        doneSrc,
  output logic [TAG_W-1:0]  doneTag,
  output logic [ACK_W-1:0]  doneCode,
  output logic              doneErr
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [TIME_W-1:0] TIME_MAX = '1;

  logic [TAG_W-1:0]  slotTag, phyTagR;
  logic              slotIsRsp, sendPhy, rrPtr;
  logic [CNT_W-1:0]  retryCnt;
  logic [TIME_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotTag   <= '0;
      phyTagR   <= '0;
      slotIsRsp <= 1'b0;
      sendPhy   <= 1'b0;
      rrPtr     <= 1'b0;
      retryCnt  <= '0;
      elapsed   <= '0;
    end else if (st.flushAll) begin
      sendPhy  <= 1'b0;
      retryCnt <= '0;
      elapsed  <= '0;
    end else begin
      if (st.grantQ) begin
        slotTag   <= st.grantRsp ? rspTag : reqTag;
        slotIsRsp <= st.grantRsp;
        rrPtr     <= ~st.grantRsp;
        sendPhy   <= 1'b0;
      end else if (st.grantPhy) begin
        phyTagR <= phyTag;
        sendPhy <= 1'b1;
      end else if (st.resend) begin
        sendPhy <= 1'b0;
      end
      if (st.grantQ || st.clearSlot)
        retryCnt <= '0;
      else if (st.bumpRetry && retryCnt != CNT_MAX)
        retryCnt <= retryCnt + 1'b1;
      if (st.grantQ || st.clearSlot)
        elapsed <= '0;
      else if (st.slotActive && cycleTick && elapsed != TIME_MAX)
        elapsed <= elapsed + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneSrc  <= '0;
      doneTag  <= '0;
      doneCode <= '0;
      doneErr  <= 1'b0;
    end else if (st.report) begin
      doneSrc  <= txSrc;
      doneTag  <= txTag;
      doneCode <= ackCode;
      doneErr  <= st.reportErr;
    end
  end

  assign exhausted   = dualPhase ? (elapsed >= timeLimit) : (retryCnt >= retryLimit);
  assign rrPreferRsp = rrPtr;
  assign sendingPhy  = sendPhy;
  assign txTag       = sendPhy ? phyTagR : slotTag;
  assign txSrc       = sendPhy ? SRC_PHY : (slotIsRsp ? SRC_RSP : SRC_REQ);
endmodule

// File: rtl/at_sched_ctrl.sv
module at_sched_ctrl
  import at_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             rspValid,
  input  logic             phyValid,
  input  logic             ackValid,
  input  logic [ACK_W-1:0] ackCode,
  input  logic             busReset,
  input  logic             resume,
  input  logic             exhausted,
  input  logic             rrPreferRsp,
  input  logic             sendingPhy,
  output logic             reqReady,
  output logic             rspReady,
  output logic             phyReady,
  output logic             txStart,
  output logic             halted,
  output logic             flushQ,
  output logic             doneValid,
  output ctrlStrobe_t      st
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e state;
  logic   retryPending, slotActive;
  logic   canArb, resendNow, qArb, pickRsp;
  logic   ackNow, busyAck, phyDone, retryNow, finishQ, launch;

  always_comb begin
    canArb    = (state == ST_IDLE) && !halted && !busReset;
    phyReady  = canArb && phyValid;
    resendNow = canArb && !phyValid && retryPending;
    qArb      = canArb && !phyValid && !retryPending;
    pickRsp   = rspValid && (!reqValid || rrPreferRsp);
    rspReady  = qArb && pickRsp;
    reqReady  = qArb && reqValid && !pickRsp;
    ackNow    = (state == ST_WAIT) && ackValid && !busReset;
    busyAck   = isBusyAck(ackCode);
    phyDone   = ackNow && sendingPhy;
    retryNow  = ackNow && !sendingPhy && busyAck && !exhausted;
    finishQ   = ackNow && !sendingPhy && !retryNow;
    launch    = reqReady || rspReady || phyReady || resendNow;

    st            = '0;
    st.grantQ     = reqReady || rspReady;
    st.grantRsp   = rspReady;
    st.grantPhy   = phyReady;
    st.resend     = resendNow;
    st.bumpRetry  = retryNow;
    st.clearSlot  = finishQ;
    st.slotActive = slotActive;
    st.report     = phyDone || finishQ;
    st.reportErr  = finishQ && busyAck;
    st.flushAll   = busReset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      halted       <= 1'b0;
      retryPending <= 1'b0;
      slotActive   <= 1'b0;
      txStart      <= 1'b0;
      flushQ       <= 1'b0;
      doneValid    <= 1'b0;
    end else begin
      txStart   <= launch;
      flushQ    <= busReset;
      doneValid <= phyDone || finishQ;
      if (busReset) begin
        state        <= ST_IDLE;
        halted       <= 1'b1;
        retryPending <= 1'b0;
        slotActive   <= 1'b0;
      end else begin
        if (resume) halted <= 1'b0;
        if (launch) state <= ST_WAIT;
        else if (ackNow) state <= ST_IDLE;
        if (retryNow) retryPending <= 1'b1;
        else if (resendNow) retryPending <= 1'b0;
        if (st.grantQ) slotActive <= 1'b1;
        else if (finishQ) slotActive <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/at_retry_sched.sv
module at_retry_sched
  import at_sched_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 4,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic              phyValid,
  output logic              phyReady,
  input  logic [TAG_W-1:0]  phyTag,
  input  logic              dualPhase,
  input  logic [CNT_W-1:0]  retryLimit,
  input  logic [TIME_W-1:0] timeLimit,
  input  logic              cycleTick,
  input  logic              ackValid,
  input  logic [3:0]        ackCode,
  input  logic              busReset,
  input  logic              resume,
  output logic              flushQ,
  output logic              halted,
  output logic              txStart,
  output logic [1:0]        txSrc,
  output logic [TAG_W-1:0]  txTag,
  output logic              doneValid,
  output logic [1:0]        doneSrc,
  output logic [TAG_W-1:0]  doneTag,
  output logic [3:0]        doneCode,
  output logic              doneErr
);
  ctrlStrobe_t st;
  logic exhausted, rrPreferRsp, sendingPhy;

  at_sched_ctrl uCtrl (
    .clk, .rstN, .reqValid, .rspValid, .phyValid, .ackValid, .ackCode,
    .busReset, .resume, .exhausted, .rrPreferRsp, .sendingPhy,
    .reqReady, .rspReady, .phyReady, .txStart, .halted, .flushQ,
    .doneValid, .st
  );

  at_sched_dpath #(.TAG_W(TAG_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) uDpath (
    .clk, .rstN, .st, .reqTag, .rspTag, .phyTag, .dualPhase, .retryLimit,
    .timeLimit, .cycleTick, .ackCode, .exhausted, .rrPreferRsp, .sendingPhy,
    .txSrc, .txTag, .doneSrc, .doneTag, .doneCode, .doneErr
  );
endmodule

// File: rtl/at_sched_chk.sv
module at_sched_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic             phyValid,
  input logic             phyReady,
  input logic             ackValid,
  input logic             busReset,
  input logic             flushQ,
  input logic             halted,
  input logic             txStart,
  input logic             doneValid,
  input logic [1:0]       doneSrc,
  input logic [3:0]       doneCode,
  input logic             doneErr
);
  logic inFlight;
  logic anyReady, anyGrant;

  assign anyReady = reqReady || rspReady || phyReady;
  assign anyGrant = (reqReady && reqValid) || (rspReady && rspValid) || (phyReady && phyValid);

  always_ff @(posedge clk) begin
    if (!rstN || busReset || ackValid) inFlight <= 1'b0;
    else if (txStart) inFlight <= 1'b1;
  end

  a_r1_hold_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    (txStart || inFlight) |-> !anyReady);

  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, rspReady, phyReady}));

  a_r10_start_follows_grant: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant |=> txStart);

  a_r8_flush_and_halt: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (flushQ && halted && !doneValid));

  a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!anyReady && !txStart));

  a_r3_err_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneErr) |-> (doneCode inside {4'h4, 4'h5, 4'h6}));

  a_r6_phy_never_err: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneSrc == 2'd2) |-> !doneErr);
endmodule

bind at_retry_sched at_sched_chk #(.TAG_W(TAG_W)) uChk (.*);

// File: tb/tb_at_retry_sched.sv
module tb_at_retry_sched;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8, CNT_W = 4, TIME_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, rspValid = 0, phyValid = 0;
  logic reqReady, rspReady, phyReady;
  logic [TAG_W-1:0] reqTag = '0, rspTag = '0, phyTag = '0;
  logic dualPhase = 0;
  logic [CNT_W-1:0] retryLimit = '0;
  logic [TIME_W-1:0] timeLimit = '0;
  logic cycleTick = 0, ackValid = 0, busReset = 0, resume = 0;
  logic [3:0] ackCode = '0;
  logic flushQ, halted, txStart, doneValid, doneErr;
  logic [1:0] txSrc, doneSrc;
  logic [TAG_W-1:0] txTag, doneTag;
  logic [3:0] doneCode;

  int nChecks = 0, nFails = 0, cycles = 0;

  at_retry_sched #(.TAG_W(TAG_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // Offer a packet from src (0 req, 1 rsp, 2 phy); return at the negedge where txStart shows.
  task automatic offer(input int src, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    case (src)
      0: begin reqValid = 1; reqTag = tag; end
      1: begin rspValid = 1; rspTag = tag; end
      default: begin phyValid = 1; phyTag = tag; end
    endcase
    #1;
    for (int i = 0; i < 10; i++) begin
      if ((src == 0 && reqReady) || (src == 1 && rspReady) || (src == 2 && phyReady)) break;
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    if (src == 0) reqValid = 0; else if (src == 1) rspValid = 0; else phyValid = 0;
    chk("R10 txStart after grant", txStart, 1);
    chk("R10 txSrc", txSrc, src);
    chk("R10 txTag", txTag, tag);
  endtask

  // Present one acknowledge; return at the negedge after it was taken.
  task automatic ack(input logic [3:0] code);
    @(negedge clk);
    ackValid = 1; ackCode = code;
    @(posedge clk);
    @(negedge clk);
    ackValid = 0;
  endtask

  task automatic waitStart(input string rq, input int src, input logic [TAG_W-1:0] tag);
    int n = 0;
    while (!txStart && n < 8) begin @(negedge clk); n++; end
    chk({rq, " resend launched"}, txStart, 1);
    chk({rq, " resend src"}, txSrc, src);
    chk({rq, " resend tag"}, txTag, tag);
  endtask

  task automatic tick();
    @(negedge clk); cycleTick = 1;
    @(negedge clk); cycleTick = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R9 reset halted", halted, 0);
    chk("R10 reset txStart", txStart, 0);
    chk("R2 reset doneValid", doneValid, 0);
    chk("R8 reset flushQ", flushQ, 0);
    chk("R10 reset ready", {reqReady, rspReady, phyReady}, 0);
  endtask

  task automatic testBasic();
    offer(0, 8'h11);
    @(negedge clk); rspValid = 1; rspTag = 8'h12;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R1 no grant while waiting", rspReady, 0);
      @(negedge clk);
    end
    ack(4'h1);
    chk("R2 doneValid", doneValid, 1);
    chk("R2 doneTag", doneTag, 8'h11);
    chk("R2 doneSrc", doneSrc, 0);
    chk("R2 doneCode", doneCode, 4'h1);
    chk("R2 doneErr", doneErr, 0);
    chk("R1 next grant after ack", rspReady, 1);
    @(posedge clk); @(negedge clk); rspValid = 0;
    chk("R10 rsp launched", txStart, 1);
    chk("R10 rsp src", txSrc, 1);
    ack(4'h2);
    chk("R2 rsp done", doneValid, 1);
    chk("R2 rsp tag", doneTag, 8'h12);
  endtask

  task automatic testCountRetry();
    dualPhase = 0; retryLimit = 4'd2;
    offer(0, 8'h22);
    ack(4'h4);
    chk("R3 first busy retried", doneValid, 0);
    waitStart("R3", 0, 8'h22);
    ack(4'h5);
    chk("R5 busyA retried", doneValid, 0);
    waitStart("R3", 0, 8'h22);
    ack(4'h6);
    chk("R3 exhausted done", doneValid, 1);
    chk("R3 exhausted err", doneErr, 1);
    chk("R3 last code", doneCode, 4'h6);
    chk("R3 tag", doneTag, 8'h22);
  endtask

  task automatic testClear();
    retryLimit = 4'd1;
    offer(0, 8'h33);
    ack(4'h4);
    chk("R3 limit1 retried", doneValid, 0);
    waitStart("R3", 0, 8'h33);
    ack(4'h1);
    chk("R2 ok after retry", doneErr, 0);
    chk("R2 ok done", doneValid, 1);
    offer(0, 8'h34);
    ack(4'h4);
    chk("R2 counter cleared", doneValid, 0);
    waitStart("R2", 0, 8'h34);
    ack(4'h3);
    chk("R5 code3 non-busy done", doneValid, 1);
    chk("R5 code3 no err", doneErr, 0);
    chk("R5 code3 value", doneCode, 4'h3);
  endtask

  task automatic testTimeRetry();
    dualPhase = 1; timeLimit = 8'd3; retryLimit = 4'd0;
    offer(1, 8'h44);
    tick(); tick();
    ack(4'h4);
    chk("R4 within budget retried", doneValid, 0);
    waitStart("R4", 1, 8'h44);
    tick();
    ack(4'h4);
    chk("R4 budget spent done", doneValid, 1);
    chk("R4 budget spent err", doneErr, 1);
    chk("R4 code", doneCode, 4'h4);
    dualPhase = 0;
  endtask

  task automatic testPhy();
    retryLimit = 4'd3;
    offer(0, 8'h55);
    @(negedge clk); phyValid = 1; phyTag = 8'h66;
    for (int i = 0; i < 2; i++) begin
      #1; chk("R6 phy waits for boundary", phyReady, 0);
      @(negedge clk);
    end
    ack(4'h4);
    #1;
    chk("R6 phy beats resend", phyReady, 1);
    chk("R6 queue not granted", reqReady, 0);
    @(posedge clk); @(negedge clk); phyValid = 0;
    chk("R6 phy launched", txStart, 1);
    chk("R6 phy src", txSrc, 2);
    chk("R6 phy tag", txTag, 8'h66);
    ack(4'h4);
    chk("R6 phy sent once", doneValid, 1);
    chk("R6 phy no err", doneErr, 0);
    chk("R6 phy done src", doneSrc, 2);
    waitStart("R6", 0, 8'h55);
    ack(4'h1);
    chk("R6 req completes after phy", doneTag, 8'h55);
  endtask

  task automatic testRoundRobin();
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      reqValid = 1; reqTag = 8'h70 + 8'(r);
      rspValid = 1; rspTag = 8'h78 + 8'(r);
      #1;
      chk("R7 rsp picked first", rspReady, 1);
      @(posedge clk); @(negedge clk); rspValid = 0;
      chk("R7 first src", txSrc, 1);
      ack(4'h1);
      #1;
      chk("R7 req next", reqReady, 1);
      @(posedge clk); @(negedge clk); reqValid = 0;
      chk("R7 second src", txSrc, 0);
      chk("R7 second tag", txTag, 8'h70 + 8'(r));
      ack(4'h1);
    end
  endtask

  task automatic testBusReset();
    offer(0, 8'h80);
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
    chk("R8 flushQ pulse", flushQ, 1);
    chk("R8 halted", halted, 1);
    chk("R8 no done", doneValid, 0);
    @(negedge clk);
    chk("R8 flushQ single", flushQ, 0);
    ack(4'h1);
    chk("R8 late ack ignored", doneValid, 0);
    reqValid = 1; reqTag = 8'h81;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 halted no ready", reqReady, 0);
      chk("R9 halted no start", txStart, 0);
      @(negedge clk);
    end
    resume = 1;
    @(negedge clk); resume = 0;
    #1;
    chk("R9 resumed", halted, 0);
    chk("R9 grant after resume", reqReady, 1);
    @(posedge clk); @(negedge clk); reqValid = 0;
    chk("R8 flushed packet not resent", txTag, 8'h81);
    ack(4'h1);
    chk("R9 new packet done", doneTag, 8'h81);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    testReset();
    testBasic();
    testCountRetry();
    testClear();
    testTimeRetry();
    testPhy();
    testRoundRobin();
    testBusReset();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule